// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block decides whether a serial peripheral core is held in reset, running, or paused. Software asks for a state by writing a 2-bit code to a state register over a simple register bus. The block then takes a fixed number of cycles to settle before the new state takes effect. A valid bit shows software when the settle is over and a new request may be written.

Three enable outputs drive the datapath. `run_en` lets the transfer engine move data. `hold_en` tells the engine to freeze in place and keep its FIFO contents. `flush` is a one-cycle pulse that clears the FIFOs, the counters, the status flags and the mode settings whenever the core lands in reset.

A paused core cannot drop straight into reset. Software must write the clear code twice in a row. A separate soft-reset address bypasses the handshake and forces reset on the next clock edge.

Top module: `runstate_ctrl`

## Requirements
- R1: After `rst_n` is released, the state reads reset (code 0) with valid high, and `run_en`, `hold_en` and `flush` are all low.
- R2: Each state code is 2 bits: reset = 0, run = 1, clear = 2, pause = 3. A write to the state address while valid is high is accepted. Valid then reads 0 for exactly SETTLE_CYC cycles. The requested state appears in the same cycle that valid returns to 1.
- R3: A state write made while valid is low is ignored. It neither changes the pending target nor starts a further handshake.
- R4: From reset, a request for run or pause is accepted directly. Run and pause may be entered from each other directly. A request equal to the current state still completes a full valid handshake.
- R5: From pause, reset is reached only by two successive accepted writes of the clear code (binary 10).
  - A single clear from pause leaves the core in pause.
  - A write of the reset code from pause leaves the core in pause.
  - A run or pause write between the two clear writes cancels the first one.
- R6: From run or reset, a write of either the clear code or the reset code leads to reset.
- R7: A write to the soft-reset address with data bit 0 set forces the core into reset at the next edge, whatever the valid flag shows. It aborts any pending handshake and leaves valid high. A write with bit 0 clear has no effect.
- R8: `flush` pulses high for one cycle when the state lands in reset coming from run or pause, and on every soft reset. It is never high outside the reset state.
- R9: `run_en` is high only in run, and `hold_en` is high only in pause.
- R10: A read of the state address returns the state code in bits [1:0] and valid in bit 2, with all other bits zero. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address (combinational read) |
| rd_data | output | DATA_W | Read data |
| run_en | output | 1 | Transfer engine may run |
| hold_en | output | 1 | Transfer engine freezes and keeps its FIFOs |
| flush | output | 1 | One-cycle clear of FIFOs, counters, status and mode |

## Verification
The assertions check three things on every cycle:
- the state never moves while a handshake is still settling;
- the settle counter never restarts while busy;
- a single clear from pause never targets reset, and `flush` only appears in reset.

Some behaviours need whole scenarios and are covered by the bench instead:
- the exact length of the low-valid window;
- the resulting state for every start state against every code;
- the cancel-between-clears sequence;
- a soft reset that aborts a handshake in flight.

// File: rtl/runstate_pkg.sv
// Package: state codes shared by the run-state controller.
// Assumes: codes are fixed by the register contract, 2 bits wide.
package runstate_pkg;
    localparam logic [1:0] CODE_RESET = 2'd0;
    localparam logic [1:0] CODE_RUN   = 2'd1;
    localparam logic [1:0] CODE_CLEAR = 2'd2;
    localparam logic [1:0] CODE_PAUSE = 2'd3;
endpackage

// File: rtl/runstate_regif.sv
// Register decode: turns bus writes into an accepted state request or a
// soft-reset strike, and builds the read word.
// Assumes: DATA_W >= 3; reads are combinational from rd_addr.
module runstate_regif #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int STATE_ADDR = 0,
    parameter int SRST_ADDR  = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        cur_state,
    input  logic              busy,
    output logic              accept,
    output logic [1:0]        req_code,
    output logic              srst,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(STATE_ADDR);
    localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(SRST_ADDR);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:2];

    // Write decode: state requests only pass when no handshake is open.
    always_comb begin
        req_code = wr_data[1:0];
        srst     = wr_en && (wr_addr == A_SRST) && wr_data[0];
        accept   = wr_en && (wr_addr == A_STATE) && !busy;
    end

    // Read mux: state word at its address, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STATE) begin
            rd_data[1:0] = cur_state;
            rd_data[2]   = !busy;
        end
    end
endmodule

// File: rtl/runstate_settle.sv
// Settle timer: holds busy for SETTLE_CYC cycles after a start and marks
// the last busy cycle with done.
// Assumes: SETTLE_CYC >= 1; start is never raised while busy.
module runstate_settle #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Countdown: load on start, clear on abort, else count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (abort)     cnt_q <= '0;
        else if (start)     cnt_q <= CNT_W'(SETTLE_CYC);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy); // R2
    AST_SETTLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !abort) |=> !busy); // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R3
endmodule

// File: rtl/runstate_fsm.sv
// State keeper: records the target of an accepted request, commits it when
// the settle timer finishes, tracks the first clear from pause, and emits
// the flush pulse on entry to reset.
// Assumes: accept and done never coincide; srst overrides everything.
module runstate_fsm
    import runstate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [1:0] req_code,
    input  logic       srst,
    input  logic       done,
    output logic [1:0] cur_state,
    output logic       flush
);
    logic [1:0] cur_q, tgt_q, nxt_tgt;
    logic       armed_q, flush_q;

    // Target rule: pause needs a second clear to reach reset.
    always_comb begin
        case (req_code)
            CODE_RUN, CODE_PAUSE: nxt_tgt = req_code;
            CODE_RESET: nxt_tgt = (cur_q == CODE_PAUSE) ? CODE_PAUSE : CODE_RESET;
            default: nxt_tgt = (cur_q == CODE_PAUSE) ?
                               (armed_q ? CODE_RESET : CODE_PAUSE) : CODE_RESET;
        endcase
    end

    // State registers: soft reset first, then accept, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= CODE_RESET;
            tgt_q   <= CODE_RESET;
            armed_q <= 1'b0;
            flush_q <= 1'b0;
        end else if (srst) begin
            cur_q   <= CODE_RESET;
            tgt_q   <= CODE_RESET;
            armed_q <= 1'b0;
            flush_q <= 1'b1;
        end else begin
            flush_q <= 1'b0;
            if (accept) begin
                tgt_q   <= nxt_tgt;
                armed_q <= (req_code == CODE_CLEAR) && (cur_q == CODE_PAUSE) && !armed_q;
            end
            if (done) begin
                cur_q   <= tgt_q;
                flush_q <= (tgt_q == CODE_RESET) && (cur_q != CODE_RESET);
            end
        end
    end

    assign cur_state = cur_q;
    assign flush     = flush_q;

    AST_HOLD_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !done) |=> $stable(cur_q)); // R3
    AST_PAUSE_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !srst && cur_q == CODE_PAUSE && !armed_q) |=> (tgt_q != CODE_RESET)); // R5
    AST_SRST_LANDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cur_q == CODE_RESET && flush_q)); // R7
    AST_FLUSH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> (cur_q == CODE_RESET)); // R8
endmodule

// File: rtl/runstate_ctrl.sv
// Top: run-state controller for a serial peripheral core. Joins the
// register decode, settle timer and state keeper, and decodes the
// datapath enables from the committed state.
// Assumes: synchronous active-low reset; single clock domain.
module runstate_ctrl
    import runstate_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int STATE_ADDR = 0,
    parameter int SRST_ADDR  = 4,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              run_en,
    output logic              hold_en,
    output logic              flush
);
    logic       accept, srst, busy, done;
    logic [1:0] req_code, cur_state;

    runstate_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STATE_ADDR(STATE_ADDR), .SRST_ADDR(SRST_ADDR)
    ) u_regif (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .cur_state(cur_state), .busy(busy),
        .accept(accept), .req_code(req_code), .srst(srst), .rd_data(rd_data)
    );

    runstate_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(accept && !srst), .abort(srst),
        .busy(busy), .done(done)
    );

    runstate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_code(req_code),
        .srst(srst), .done(done), .cur_state(cur_state), .flush(flush)
    );

    // Datapath enables: decoded from the committed state only.
    always_comb begin
        run_en  = (cur_state == CODE_RUN);
        hold_en = (cur_state == CODE_PAUSE);
    end
endmodule

// File: tb/runstate_ctrl_bench.sv
module runstate_ctrl_bench;
    localparam int AW = 4, DW = 32, SA = 0, RA = 4, S = 4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = AW'(SA);
    logic [DW-1:0] wr_data = '0, rd_data;
    logic run_en, hold_en, flush;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    runstate_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STATE_ADDR(SA),
                    .SRST_ADDR(RA), .SETTLE_CYC(S)) u_runstate_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .run_en(run_en), .hold_en(hold_en), .flush(flush));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (S) @(negedge clk);
    endtask

    task automatic goto_state(input logic [1:0] st);
        wr(RA, 32'h1);
        if (st != 2'd0) begin wr(SA, {30'd0, st}); settle(); end
    endtask

    function automatic logic [1:0] expect_next(input logic [1:0] cur, input logic [1:0] code);
        if (code == 2'd1 || code == 2'd3) return code;
        if (cur == 2'd3) return 2'd3;  // R5: single clear or reset code stays in pause
        return 2'd0;                   // R6
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 state", rd_data, 32'h4);
        chk("R1 enables", {29'd0, run_en, hold_en, flush}, 32'h0);

        // Sweep every start state against every code (R2, R4, R5, R6, R8, R9)
        foreach (rd_data[i]) begin end
        for (int si = 0; si < 3; si++) begin
            for (int c = 0; c < 4; c++) begin
                logic [1:0] st, ex;
                st = (si == 2) ? 2'd3 : 2'(si);
                ex = expect_next(st, 2'(c));
                goto_state(st);
                wr(SA, 32'(c));
                chk("R2 valid low", {31'd0, rd_data[2]}, 32'h0);
                for (int k = 1; k < S; k++) begin
                    @(negedge clk);
                    chk("R2 valid still low", {31'd0, rd_data[2]}, 32'h0);
                end
                @(negedge clk);
                chk("R2 valid back", {31'd0, rd_data[2]}, 32'h1);
                chk(st == 2'd3 ? "R5 sweep state" : (c == 1 || c == 3) ? "R4 sweep state" : "R6 sweep state",
                    {30'd0, rd_data[1:0]}, {30'd0, ex});
                chk("R9 run_en", {31'd0, run_en}, {31'd0, ex == 2'd1});
                chk("R9 hold_en", {31'd0, hold_en}, {31'd0, ex == 2'd3});
                chk("R8 flush on entry", {31'd0, flush}, {31'd0, ex == 2'd0 && st != 2'd0});
                chk("R10 upper zero", {3'd0, rd_data[31:3]}, 32'h0);
                @(negedge clk);
                chk("R8 flush one cycle", {31'd0, flush}, 32'h0);
            end
        end

        // R3: write during settle is ignored
        goto_state(2'd0);
        wr(SA, 32'h1);
        wr(SA, 32'h3);
        repeat (S - 1) @(negedge clk);
        chk("R3 target kept", {29'd0, rd_data[2:0]}, 32'h5);
        repeat (S + 1) @(negedge clk);
        chk("R3 no second handshake", {29'd0, rd_data[2:0]}, 32'h5);

        // R5: two clears from pause reach reset
        goto_state(2'd3);
        wr(SA, 32'h2); settle();
        chk("R5 first clear", {29'd0, rd_data[2:0]}, 32'h7);
        wr(SA, 32'h2); settle();
        chk("R5 second clear", {29'd0, rd_data[2:0]}, 32'h4);
        chk("R8 flush from pause", {31'd0, flush}, 32'h1);

        // R5: intervening pause write cancels the first clear
        goto_state(2'd3);
        wr(SA, 32'h2); settle();
        wr(SA, 32'h3); settle();
        wr(SA, 32'h2); settle();
        chk("R5 cancel", {29'd0, rd_data[2:0]}, 32'h7);

        // R7: soft reset from run
        goto_state(2'd1);
        wr(RA, 32'h1);
        chk("R7 srst state", {29'd0, rd_data[2:0]}, 32'h4);
        chk("R8 srst flush", {31'd0, flush}, 32'h1);
        // R7: soft reset aborts a pending handshake
        wr(SA, 32'h1);
        wr(RA, 32'h1);
        chk("R7 abort", {29'd0, rd_data[2:0]}, 32'h4);
        repeat (S + 1) @(negedge clk);
        chk("R7 abort holds", {29'd0, rd_data[2:0]}, 32'h4);
        // R7: bit 0 clear has no effect
        goto_state(2'd1);
        wr(RA, 32'hFFFF_FFFE);
        chk("R7 bit0 clear", {29'd0, rd_data[2:0]}, 32'h5);
        chk("R7 no flush", {31'd0, flush}, 32'h0);

        // R10: other addresses read zero
        rd_addr = AW'(RA);
        @(negedge clk);
        chk("R10 srst addr reads zero", rd_data, 32'h0);
        rd_addr = AW'(8);
        @(negedge clk);
        chk("R10 spare addr reads zero", rd_data, 32'h0);
        rd_addr = AW'(SA);
        @(negedge clk);
        chk("R10 state word", rd_data, 32'h5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule